// File: doc/BRIEF.md
# Oscilloscope Edge and Pulse Trigger

This block watches a stream of sample pairs from a two-channel 8-bit oscilloscope front end and raises a single-cycle trigger strobe when a programmed condition is met. One source is chosen: channel A samples, channel B samples, or an external logic-level trigger input. An analog source is turned into a clean digital level by a comparator with hysteresis. The level rises only when a sample is above the upper threshold. It falls only when a sample is below the lower threshold. Between the two thresholds the level keeps its value. The external source is already digital and goes straight to the level.

The level then feeds an event detector with four kinds. Two kinds are plain edges: rising or falling. Two kinds are pulses: a positive pulse or a negative pulse. The width of a pulse is counted in accepted samples. At the closing edge the width is compared with a 32-bit programmed duration. The comparison is either "shorter than" or "longer than". Software loads the duration as two 16-bit halves: the upper half first, then the lower half. Writing the lower half loads the whole value into the active register in one step.

Samples arrive on a valid/ready interface. The block never applies back-pressure, so ready is high whenever reset is released. Only cycles with valid high are evaluated. The configuration inputs are plain static levels. The trigger output is a plain strobe.

Top module: `scope_trig_top`

## Requirements
- R1: `smp_ready` is high whenever reset is released. A cycle with `smp_valid` low changes neither the level nor the pulse width, and never produces a trigger.
- R2: `thr_cfg[15:8]` holds the upper threshold and `thr_cfg[7:0]` holds the lower threshold. The level goes to 1 when an accepted sample is strictly above the upper threshold. It goes to 0 when an accepted sample is strictly below the lower threshold. Otherwise it holds, including when the sample equals either threshold. The level is 0 after reset.
- R3: `trig_src` selects the source. 00 selects channel A (`ch_a_smp`) and 01 selects channel B (`ch_b_smp`). Codes 10 and 11 select `ext_trig`, which becomes the level directly and skips both thresholds.
- R4: With `trig_type` = 00, a 0-to-1 level change on an accepted sample sets `trig_out` in the next clock cycle.
- R5: With `trig_type` = 01, a 1-to-0 level change on an accepted sample sets `trig_out` in the next clock cycle.
- R6: With `trig_type` = 10, a positive pulse opens on a rising level change and closes on the following falling change. Its width is the number of accepted samples from the opening sample up to, but not including, the closing sample. The trigger fires in the cycle after the closing sample if the width test passes. The opening edge never fires.
- R7: With `trig_type` = 11, the same rules apply as in R6, with the roles of the edges swapped: the pulse opens on a falling change and closes on the following rising change.
- R8: With `pulse_longer` = 0, a pulse passes when its width is strictly below the programmed duration. With `pulse_longer` = 1, it passes when its width is strictly above it. A width equal to the duration never fires.
- R9: A `ptime_wr_hi` strobe stores `ptime_wdata` as the pending upper half and leaves the active duration unchanged. A `ptime_wr_lo` strobe loads the active duration with {pending upper half, `ptime_wdata`}. The active duration is 0 after reset.
- R10: `trig_out` is low during and after reset and never stays high for two cycles in a row.
- R11: A closing edge that was not preceded by an opening edge in a pulse mode does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample pair valid |
| smp_ready | output | 1 | Sample pair accepted (always high when out of reset) |
| ch_a_smp | input | 8 | Channel A sample |
| ch_b_smp | input | 8 | Channel B sample |
| ext_trig | input | 1 | External digital trigger input, qualified by smp_valid |
| thr_cfg | input | 16 | Upper threshold [15:8], lower threshold [7:0] |
| trig_type | input | 2 | 00 rise, 01 fall, 10 positive pulse, 11 negative pulse |
| trig_src | input | 2 | 00 channel A, 01 channel B, 1x external |
| pulse_longer | input | 1 | Pulse width test: 0 shorter than, 1 longer than |
| ptime_wr_hi | input | 1 | Strobe: store upper half of duration |
| ptime_wr_lo | input | 1 | Strobe: load lower half and commit duration |
| ptime_wdata | input | 16 | Duration half-word |
| trig_out | output | 1 | One-cycle trigger strobe |

## Verification
The bench builds the block with its default parameters: 8-bit samples and a 32-bit duration made of two 16-bit halves. Pulses are only a few samples wide, so the upper half of the duration is checked through the pulse decision itself. After an upper-half write alone, a pulse that is longer than 0 but shorter than 65536 samples still triggers. After the lower-half commit of {1, 3} the same kind of pulse no longer triggers. The 8-bit thresholds let the bench hit the equal-to-threshold holding cases exactly. It also drives samples on idle cycles to show that they are ignored.

// File: rtl/scope_trig_pkg.sv
package scope_trig_pkg;
  typedef enum logic [1:0] {
    K_RISE = 2'b00,
    K_FALL = 2'b01,
    K_PPOS = 2'b10,
    K_PNEG = 2'b11
  } trig_kind_e;

  typedef enum logic [1:0] {
    S_CHA     = 2'b00,
    S_CHB     = 2'b01,
    S_EXT     = 2'b10,
    S_EXT_ALT = 2'b11
  } trig_src_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/st_level_cond.sv
module st_level_cond
  import scope_trig_pkg::*;
#(
  parameter int SMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SMP_W-1:0] smp_a,
  input  logic [SMP_W-1:0] smp_b,
  input  logic             ext,
  input  trig_src_e        src,
  input  logic [SMP_W-1:0] thr_hi,
  input  logic [SMP_W-1:0] thr_lo,
  output logic             lvl_q,
  output logic             lvl_d
);
  logic [SMP_W-1:0] smp_arr [NUM_CH];
  logic [NUM_CH-1:0] above;
  logic [NUM_CH-1:0] below;

  assign smp_arr[0] = smp_a;
  assign smp_arr[1] = smp_b;

  // one comparator pair per channel
  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    assign above[g] = smp_arr[g] > thr_hi;
    assign below[g] = smp_arr[g] < thr_lo;
  end

  logic idx;
  assign idx = src[0];

  always_comb begin
    if (src[1]) begin
      lvl_d = ext;                 // digital source bypasses thresholds
    end else if (above[idx]) begin
      lvl_d = 1'b1;
    end else if (below[idx]) begin
      lvl_d = 1'b0;
    end else begin
      lvl_d = lvl_q;               // inside the hysteresis band
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (en) begin
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/st_ptime_reg.sv
module st_ptime_reg #(
  parameter int HALF_W = 16,
  localparam int TIME_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [HALF_W-1:0] wdata,
  output logic [TIME_W-1:0] ptime
);
  logic [HALF_W-1:0] pend_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_hi_q <= '0;
      ptime     <= '0;
    end else begin
      if (wr_hi) pend_hi_q <= wdata;
      if (wr_lo) ptime     <= {pend_hi_q, wdata};
    end
  end
endmodule

// File: rtl/st_event_det.sv
module st_event_det
  import scope_trig_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             lvl_q,
  input  logic             lvl_d,
  input  trig_kind_e       kind,
  input  logic             longer,
  input  logic [CNT_W-1:0] ptime,
  output logic             trig_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             rise, fall, is_pulse, open_e, close_e, width_ok, fire;
  logic             armed_q;
  logic [CNT_W-1:0] width_q;

  assign rise     = en & lvl_d & ~lvl_q;
  assign fall     = en & ~lvl_d & lvl_q;
  assign is_pulse = kind[1];
  assign open_e   = is_pulse & ((kind == K_PPOS) ? rise : fall);
  assign close_e  = is_pulse & ((kind == K_PPOS) ? fall : rise);
  assign width_ok = longer ? (width_q > ptime) : (width_q < ptime);

  always_comb begin
    unique case (kind)
      K_RISE:  fire = rise;
      K_FALL:  fire = fall;
      default: fire = close_e & armed_q & width_ok;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      armed_q <= 1'b0;
      width_q <= '0;
    end else begin
      trig_q <= fire;
      if (!is_pulse) begin
        armed_q <= 1'b0;
      end else if (open_e) begin
        armed_q <= 1'b1;
        width_q <= {{(CNT_W-1){1'b0}}, 1'b1};
      end else if (close_e) begin
        armed_q <= 1'b0;
      end else if (armed_q && en && width_q != CNT_MAX) begin
        width_q <= width_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scope_trig_top.sv
module scope_trig_top
  import scope_trig_pkg::*;
#(
  parameter int SMP_W  = 8,
  parameter int HALF_W = 16,
  localparam int TIME_W = 2 * HALF_W,
  localparam int THR_W  = 2 * SMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  ch_a_smp,
  input  logic [SMP_W-1:0]  ch_b_smp,
  input  logic              ext_trig,
  input  logic [THR_W-1:0]  thr_cfg,
  input  logic [1:0]        trig_type,
  input  logic [1:0]        trig_src,
  input  logic              pulse_longer,
  input  logic              ptime_wr_hi,
  input  logic              ptime_wr_lo,
  input  logic [HALF_W-1:0] ptime_wdata,
  output logic              trig_out
);
  logic              accept;
  logic              lvl_q, lvl_d;
  logic [TIME_W-1:0] ptime_act;

  assign smp_ready = rst_n;
  assign accept    = smp_valid & smp_ready;

  st_level_cond #(.SMP_W(SMP_W)) u_level (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (accept),
    .smp_a  (ch_a_smp),
    .smp_b  (ch_b_smp),
    .ext    (ext_trig),
    .src    (trig_src_e'(trig_src)),
    .thr_hi (thr_cfg[THR_W-1:SMP_W]),
    .thr_lo (thr_cfg[SMP_W-1:0]),
    .lvl_q  (lvl_q),
    .lvl_d  (lvl_d)
  );

  st_ptime_reg #(.HALF_W(HALF_W)) u_ptime (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_hi (ptime_wr_hi),
    .wr_lo (ptime_wr_lo),
    .wdata (ptime_wdata),
    .ptime (ptime_act)
  );

  st_event_det #(.CNT_W(TIME_W)) u_event (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (accept),
    .lvl_q  (lvl_q),
    .lvl_d  (lvl_d),
    .kind   (trig_kind_e'(trig_type)),
    .longer (pulse_longer),
    .ptime  (ptime_act),
    .trig_q (trig_out)
  );
endmodule

// File: rtl/st_trig_chk.sv
module st_trig_chk #(
  parameter int SMP_W  = 8,
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic                smp_ready,
  input logic [SMP_W-1:0]    ch_a_smp,
  input logic [SMP_W-1:0]    ch_b_smp,
  input logic                ext_trig,
  input logic [2*SMP_W-1:0]  thr_cfg,
  input logic [1:0]          trig_type,
  input logic [1:0]          trig_src,
  input logic                ptime_wr_lo,
  input logic [HALF_W-1:0]   ptime_wdata,
  input logic                trig_out,
  input logic [2*HALF_W-1:0] ptime_act
);
  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n) smp_ready);

  assert_valid_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> $past(smp_valid));

  assert_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);

  assert_rise_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && $past(trig_type == 2'b00 && trig_src == 2'b00))
      |-> $past(ch_a_smp) > $past(thr_cfg[2*SMP_W-1:SMP_W]));

  assert_fall_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && $past(trig_type == 2'b01 && trig_src == 2'b01))
      |-> $past(ch_b_smp) < $past(thr_cfg[SMP_W-1:0]));

  assert_ext_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && $past(trig_type == 2'b00 && trig_src[1])) |-> $past(ext_trig));

  assert_hold_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ptime_wr_lo |=> $stable(ptime_act));

  assert_commit_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptime_wr_lo |=> ptime_act[HALF_W-1:0] == $past(ptime_wdata));
endmodule

bind scope_trig_top st_trig_chk #(.SMP_W(SMP_W), .HALF_W(HALF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .ch_a_smp    (ch_a_smp),
  .ch_b_smp    (ch_b_smp),
  .ext_trig    (ext_trig),
  .thr_cfg     (thr_cfg),
  .trig_type   (trig_type),
  .trig_src    (trig_src),
  .ptime_wr_lo (ptime_wr_lo),
  .ptime_wdata (ptime_wdata),
  .trig_out    (trig_out),
  .ptime_act   (ptime_act)
);

// File: tb/tb_scope_trig_top.sv
module tb_scope_trig_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [7:0]  ch_a_smp = '0;
  logic [7:0]  ch_b_smp = '0;
  logic        ext_trig = 1'b0;
  logic [15:0] thr_cfg = 16'h8040;
  logic [1:0]  trig_type = 2'b00;
  logic [1:0]  trig_src = 2'b00;
  logic        pulse_longer = 1'b0;
  logic        ptime_wr_hi = 1'b0;
  logic        ptime_wr_lo = 1'b0;
  logic [15:0] ptime_wdata = '0;
  logic        trig_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  scope_trig_top dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .ch_a_smp(ch_a_smp), .ch_b_smp(ch_b_smp), .ext_trig(ext_trig),
    .thr_cfg(thr_cfg), .trig_type(trig_type), .trig_src(trig_src),
    .pulse_longer(pulse_longer), .ptime_wr_hi(ptime_wr_hi),
    .ptime_wr_lo(ptime_wr_lo), .ptime_wdata(ptime_wdata), .trig_out(trig_out)
  );

  task automatic chk(input logic act, input logic exp, input string rq, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", rq, what, act, exp);
    end
  endtask

  // one accepted sample; returns trig_out of the following cycle
  task automatic push(input logic [7:0] a, input logic [7:0] b, input logic e, output logic f);
    smp_valid = 1'b1; ch_a_smp = a; ch_b_smp = b; ext_trig = e;
    @(posedge clk);
    @(negedge clk);
    f = trig_out;
    smp_valid = 1'b0;
  endtask

  task automatic push_chk(input logic [7:0] a, input logic [7:0] b, input logic e,
                          input logic exp, input string rq, input string what);
    logic f;
    push(a, b, e, f);
    chk(f, exp, rq, what);
  endtask

  task automatic set_cfg(input logic [1:0] ty, input logic [1:0] sr, input logic [15:0] thr,
                         input logic lg);
    trig_type = ty; trig_src = sr; thr_cfg = thr; pulse_longer = lg;
    @(negedge clk);
  endtask

  task automatic wr_half(input logic hi, input logic [15:0] v);
    ptime_wdata = v; ptime_wr_hi = hi; ptime_wr_lo = ~hi;
    @(posedge clk);
    @(negedge clk);
    ptime_wr_hi = 1'b0; ptime_wr_lo = 1'b0;
  endtask

  // baseline, w samples at polarity p, then closing sample
  task automatic pulse(input logic p, input int w, input logic exp, input string rq);
    push_chk(8'h00, 8'h00, ~p, 1'b0, rq, "baseline");
    for (int i = 0; i < w; i++) push_chk(8'h00, 8'h00, p, 1'b0, rq, "inside pulse");
    push_chk(8'h00, 8'h00, ~p, exp, rq, $sformatf("close width %0d", w));
  endtask

  task automatic t_reset;
    chk(trig_out, 1'b0, "R10", "trig low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(smp_ready, 1'b1, "R1", "ready after reset");
    chk(trig_out, 1'b0, "R10", "trig low after reset");
  endtask

  task automatic t_hyst_rise;
    set_cfg(2'b00, 2'b00, 16'h8040, 1'b0);
    push_chk(8'h30, 8'hFF, 1'b1, 1'b0, "R2", "low sample");
    push_chk(8'h80, 8'hFF, 1'b1, 1'b0, "R2", "equal upper holds");
    push_chk(8'h81, 8'h00, 1'b0, 1'b1, "R4", "rise above upper");
    push_chk(8'h60, 8'h00, 1'b0, 1'b0, "R2", "in band holds");
    push_chk(8'h90, 8'h00, 1'b0, 1'b0, "R2", "no second rise");
    push_chk(8'h40, 8'h00, 1'b0, 1'b0, "R2", "equal lower holds");
    push_chk(8'h3F, 8'h00, 1'b0, 1'b0, "R2", "falls below lower");
    push_chk(8'h85, 8'h00, 1'b0, 1'b1, "R4", "rise again");
    // idle cycle with a low sample must not drop the level
    ch_a_smp = 8'h00;
    repeat (3) begin
      @(negedge clk);
      chk(trig_out, 1'b0, "R1", "no trig on idle");
    end
    push_chk(8'h00, 8'h00, 1'b0, 1'b0, "R1", "drop after idle");
    ch_a_smp = 8'hFF;
    @(negedge clk);
    chk(trig_out, 1'b0, "R1", "idle high sample ignored");
    push_chk(8'h50, 8'h00, 1'b0, 1'b0, "R1", "band after idle high");
    push_chk(8'hC0, 8'h00, 1'b0, 1'b1, "R4", "rise after idle");
  endtask

  task automatic t_fall_chb;
    set_cfg(2'b01, 2'b01, 16'h8040, 1'b0);
    push_chk(8'h00, 8'hF0, 1'b0, 1'b0, "R3", "chB high");
    push_chk(8'hFF, 8'h10, 1'b0, 1'b1, "R5", "chB falls");
    push_chk(8'h00, 8'h10, 1'b0, 1'b0, "R5", "stays low");
    push_chk(8'h00, 8'hF0, 1'b0, 1'b0, "R5", "rise ignored");
    push_chk(8'h00, 8'h20, 1'b0, 1'b1, "R5", "fall again");
    push_chk(8'h00, 8'h20, 1'b0, 1'b0, "R3", "chA change ignored");
  endtask

  task automatic t_ext;
    set_cfg(2'b00, 2'b10, 16'h8040, 1'b0);
    push_chk(8'hFF, 8'hFF, 1'b0, 1'b0, "R3", "ext low, channels high");
    push_chk(8'h00, 8'h00, 1'b1, 1'b1, "R3", "ext rise bypasses thresholds");
    push_chk(8'h00, 8'h00, 1'b1, 1'b0, "R3", "ext held");
    push_chk(8'h00, 8'h00, 1'b0, 1'b0, "R3", "ext fall");
    set_cfg(2'b00, 2'b11, 16'h8040, 1'b0);
    push_chk(8'h00, 8'h00, 1'b1, 1'b1, "R3", "code 11 is ext");
    push_chk(8'h00, 8'h00, 1'b0, 1'b0, "R3", "code 11 fall");
  endtask

  task automatic t_ptime;
    set_cfg(2'b10, 2'b10, 16'h8040, 1'b1);
    wr_half(1'b1, 16'h0001);
    pulse(1'b1, 2, 1'b1, "R9");           // active still 0
    wr_half(1'b0, 16'h0003);
    pulse(1'b1, 5, 1'b0, "R9");           // active 65539
    wr_half(1'b1, 16'h0000);
    pulse(1'b1, 5, 1'b0, "R9");           // upper alone not committed
    wr_half(1'b0, 16'h0003);
    pulse(1'b1, 5, 1'b1, "R9");           // active 3
  endtask

  task automatic t_pos_pulse;
    set_cfg(2'b10, 2'b10, 16'h8040, 1'b0);
    pulse(1'b1, 2, 1'b1, "R6");
    pulse(1'b1, 3, 1'b0, "R8");
    pulse(1'b1, 4, 1'b0, "R8");
    set_cfg(2'b10, 2'b10, 16'h8040, 1'b1);
    pulse(1'b1, 4, 1'b1, "R8");
    pulse(1'b1, 3, 1'b0, "R8");
    pulse(1'b1, 2, 1'b0, "R8");
    // idle cycles inside a pulse do not add width
    set_cfg(2'b10, 2'b10, 16'h8040, 1'b0);
    push_chk(8'h00, 8'h00, 1'b0, 1'b0, "R6", "baseline");
    push_chk(8'h00, 8'h00, 1'b1, 1'b0, "R6", "open");
    ext_trig = 1'b1;
    repeat (6) @(negedge clk);
    push_chk(8'h00, 8'h00, 1'b1, 1'b0, "R6", "second sample");
    push_chk(8'h00, 8'h00, 1'b0, 1'b1, "R6", "close width 2 with gaps");
  endtask

  task automatic t_neg_pulse;
    set_cfg(2'b11, 2'b10, 16'h8040, 1'b0);
    push_chk(8'h00, 8'h00, 1'b0, 1'b0, "R11", "level low");
    push_chk(8'h00, 8'h00, 1'b1, 1'b0, "R11", "close without open");
    pulse(1'b0, 2, 1'b1, "R7");
    pulse(1'b0, 3, 1'b0, "R7");
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_hyst_rise();
    t_fall_chb();
    t_ext();
    t_ptime();
    t_pos_pulse();
    t_neg_pulse();
    done = 1'b1;
    report();
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end
endmodule